// File: doc/BRIEF.md
# UART FIFO Threshold and DMA Request Controller

This block is the buffering and request logic that sits between a UART's host bus and its serializer. It holds a receive queue and a transmit queue of 8-bit characters, 32 entries deep by default. A single 8-bit control register, written over a one-cycle write strobe, configures them. From the fill level of each queue the block raises a receive-data interrupt, a transmit-empty interrupt and two active-low DMA request pins: one asks for the receive queue to be read and one asks for the transmit queue to be written.

The host fills the transmit queue and drains the receive queue through valid/ready streams. A transfer happens on every clock edge where valid and ready are both high. `tx_in_ready` falls when the transmit queue is full, so the host must hold its character until ready returns. `rx_out_valid` is high whenever the receive queue holds a character, and `rx_out_data` then shows the oldest one. The serializer side cannot stall. It pushes received characters with a strobe, and characters that do not fit are dropped. It takes transmit characters with a pop strobe.

With queues disabled, each direction behaves as a single-character holding register. With queues enabled, the request pins either follow single characters or, in block mode, follow the programmed thresholds.

Top module: `uart_fifo_ctl`

## Requirements
- R1: While reset is asserted, `rx_irq` and `tx_irq` are 0, `rxrdy_n` and `txrdy_n` are 1, `rx_overrun` is 0 and both queues are empty.
- R2: Each queue returns characters in the order it accepted them. The capacity is DEPTH (32) when control bit 0 is 1 and one character when it is 0. `tx_in_ready` is low exactly when the transmit queue is full. `rx_out_valid` is high exactly when the receive queue is not empty.
- R3: A serializer push into a full receive queue is discarded and sets `rx_overrun`. The flag stays set until the receive queue is flushed.
- R4: A transmit pop on an empty queue leaves the count unchanged, and `tx_ser_data` keeps showing the last character popped.
- R5: A control write with bit 1 set empties the receive queue by the next cycle, and bit 2 does the same for the transmit queue. These bits are not stored. A control write that changes bit 0 empties both queues.
- R6: With queues enabled, `rx_irq` is 1 when the receive count is at least the receive threshold. Control bits 7:6 select that threshold: 00/01/10/11 give 8/16/24/28. With queues disabled, `rx_irq` is 1 when a character is held.
- R7: With queues enabled, `tx_irq` is 1 when the transmit count is below the transmit threshold. Control bits 5:4 select that threshold: 00/01/10/11 give 16/8/24/30. With queues disabled, `tx_irq` is 1 when the transmit holder is empty.
- R8: In single-character mode (bit 0 = 0, or bit 0 = 1 with bit 3 = 0), `rxrdy_n` is 0 exactly when the receive queue is not empty, and `txrdy_n` is 0 exactly when the transmit queue is empty.
- R9: In block mode (bit 0 = 1 and bit 3 = 1), `rxrdy_n` is 0 exactly when the receive count is at least the receive threshold, and `txrdy_n` is 0 exactly when the transmit count is below the transmit threshold. The queues keep accepting characters past the threshold.
- R10: `rx_irq`, `tx_irq`, `rxrdy_n` and `txrdy_n` are registered. Each changes one clock after the count or control change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| tx_in_valid | input | 1 | Host offers a transmit character |
| tx_in_ready | output | 1 | Transmit queue can accept a character |
| tx_in_data | input | W | Transmit character from host |
| rx_out_valid | output | 1 | Receive queue holds a character |
| rx_out_ready | input | 1 | Host takes the oldest received character |
| rx_out_data | output | W | Oldest received character |
| rx_ser_push | input | 1 | Serializer delivers a received character |
| rx_ser_data | input | W | Received character from serializer |
| rx_overrun | output | 1 | Sticky: a received character was dropped |
| tx_ser_pop | input | 1 | Serializer takes the next transmit character |
| tx_ser_data | output | W | Head of transmit queue, or last popped when empty |
| tx_ser_empty | output | 1 | Transmit queue is empty |
| rx_irq | output | 1 | Receive data interrupt |
| tx_irq | output | 1 | Transmit empty interrupt |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| txrdy_n | output | 1 | Active-low transmit DMA request |

## Verification
The bench fills both queues to one below, exactly at, and above every threshold encoding, in both request modes and with queues disabled. A comparison that is off by one, or a swapped encoding table, shows up as a wrong interrupt or request level. It drives the receive queue to 33 pushes and reads back all 32 stored characters: a design that overwrote the oldest entry or wrapped its count would return wrong data or lose the overrun flag. It pops an empty transmit queue, checks the output one cycle after a push to catch request pins that were made combinational, and checks that flushing one queue leaves the other untouched and that toggling the enable bit empties both.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       dma_mode;
    logic       fifo_en;
  } ctl_t;

  function automatic logic [7:0] rx_level(input logic [1:0] sel);
    case (sel)
      2'b00:   rx_level = 8'd8;
      2'b01:   rx_level = 8'd16;
      2'b10:   rx_level = 8'd24;
      default: rx_level = 8'd28;
    endcase
  endfunction

  function automatic logic [7:0] tx_level(input logic [1:0] sel);
    case (sel)
      2'b00:   tx_level = 8'd16;
      2'b01:   tx_level = 8'd8;
      2'b10:   tx_level = 8'd24;
      default: tx_level = 8'd30;
    endcase
  endfunction

endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output ctl_t       ctl,
  output logic       rx_flush,
  output logic       tx_flush
);

  logic en_change;

  // bits 1 and 2 act only during the write cycle; a change of bit 0 empties both queues
  assign en_change = wr_en && (wr_data[0] != ctl.fifo_en);
  assign rx_flush  = (wr_en && wr_data[1]) || en_change;
  assign tx_flush  = (wr_en && wr_data[2]) || en_change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl.fifo_en  <= wr_data[0];
      ctl.dma_mode <= wr_data[3];
      ctl.tx_sel   <= wr_data[5:4];
      ctl.rx_sel   <= wr_data[7:6];
    end
  end

endmodule

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [W-1:0]  last_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    step = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = single ? !empty : (count == CW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = empty ? last_q : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      count  <= '0;
      last_q <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= step(wptr);
      if (pop_ok) begin
        rptr   <= step(rptr);
        last_q <= mem[rptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ufc_req_gen.sv
module ufc_req_gen
  import uart_fifo_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          rxrdy_n,
  output logic          txrdy_n
);

  logic [CW-1:0] rx_thr, tx_thr;
  logic          rx_hit, tx_low, block;
  logic          rx_irq_d, tx_irq_d, rxrdy_d, txrdy_d;

  assign rx_thr = CW'(rx_level(ctl.rx_sel));
  assign tx_thr = CW'(tx_level(ctl.tx_sel));
  assign rx_hit = (rx_count >= rx_thr);
  assign tx_low = (tx_count < tx_thr);
  assign block  = ctl.fifo_en && ctl.dma_mode;

  always_comb begin
    rx_irq_d = ctl.fifo_en ? rx_hit : (rx_count != '0);
    tx_irq_d = ctl.fifo_en ? tx_low : (tx_count == '0);
    if (block) begin
      rxrdy_d = !rx_hit;
      txrdy_d = !tx_low;
    end else begin
      rxrdy_d = (rx_count == '0);
      txrdy_d = (tx_count != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_irq  <= 1'b0;
      tx_irq  <= 1'b0;
      rxrdy_n <= 1'b1;
      txrdy_n <= 1'b1;
    end else begin
      rx_irq  <= rx_irq_d;
      tx_irq  <= tx_irq_d;
      rxrdy_n <= rxrdy_d;
      txrdy_n <= txrdy_d;
    end
  end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic [7:0]   ctl_wdata,
  input  logic         tx_in_valid,
  output logic         tx_in_ready,
  input  logic [W-1:0] tx_in_data,
  output logic         rx_out_valid,
  input  logic         rx_out_ready,
  output logic [W-1:0] rx_out_data,
  input  logic         rx_ser_push,
  input  logic [W-1:0] rx_ser_data,
  output logic         rx_overrun,
  input  logic         tx_ser_pop,
  output logic [W-1:0] tx_ser_data,
  output logic         tx_ser_empty,
  output logic         rx_irq,
  output logic         tx_irq,
  output logic         rxrdy_n,
  output logic         txrdy_n
);

  localparam int CW = $clog2(DEPTH + 1);

  ctl_t          ctl_q;
  logic          rx_flush, tx_flush;
  logic          fifo_en, dma_mode;
  logic [1:0]    rx_sel, tx_sel;
  logic [CW-1:0] rx_count, tx_count;
  logic          rx_full, rx_empty, tx_full;
  logic          tx_push, rx_pop;

  assign fifo_en  = ctl_q.fifo_en;
  assign dma_mode = ctl_q.dma_mode;
  assign rx_sel   = ctl_q.rx_sel;
  assign tx_sel   = ctl_q.tx_sel;

  ufc_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_we),
    .wr_data  (ctl_wdata),
    .ctl      (ctl_q),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  assign tx_in_ready  = !tx_full;
  assign tx_push      = tx_in_valid && tx_in_ready;
  assign rx_out_valid = !rx_empty;
  assign rx_pop       = rx_out_valid && rx_out_ready;

  ufc_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_q (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (rx_flush),
    .single (!fifo_en),
    .push   (rx_ser_push),
    .din    (rx_ser_data),
    .pop    (rx_pop),
    .dout   (rx_out_data),
    .count  (rx_count),
    .full   (rx_full),
    .empty  (rx_empty)
  );

  ufc_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_q (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (tx_flush),
    .single (!fifo_en),
    .push   (tx_push),
    .din    (tx_in_data),
    .pop    (tx_ser_pop),
    .dout   (tx_ser_data),
    .count  (tx_count),
    .full   (tx_full),
    .empty  (tx_ser_empty)
  );

  // dropped receive characters are remembered until the receive queue is emptied by a flush
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rx_overrun <= 1'b0;
    else if (rx_flush)                 rx_overrun <= 1'b0;
    else if (rx_ser_push && rx_full)   rx_overrun <= 1'b1;
  end

  ufc_req_gen #(.CW(CW)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl_q),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq),
    .rxrdy_n  (rxrdy_n),
    .txrdy_n  (txrdy_n)
  );

endmodule

// File: rtl/ufc_checker.sv
module ufc_checker
  import uart_fifo_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          dma_mode,
  input logic [1:0]    rx_sel,
  input logic [1:0]    tx_sel,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_flush,
  input logic          tx_flush,
  input logic          tx_push,
  input logic          rx_overrun,
  input logic          rx_irq,
  input logic          rxrdy_n,
  input logic          txrdy_n,
  input logic          tx_ser_pop,
  input logic          tx_ser_empty,
  input logic [W-1:0]  tx_ser_data
);

  logic [CW-1:0] rx_thr, tx_thr;
  assign rx_thr = CW'(rx_level(rx_sel));
  assign tx_thr = CW'(tx_level(tx_sel));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH))); // R2

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !rx_flush) |=> rx_overrun); // R3

  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ser_pop && tx_ser_empty && !tx_push) |=> $stable(tx_ser_data)); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_count == '0)); // R5

  AST_RX_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_count >= rx_thr) |=> rx_irq); // R6

  AST_RXRDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fifo_en && dma_mode) && rx_count != '0) |=> !rxrdy_n); // R8

  AST_TXRDY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && dma_mode && tx_count >= tx_thr) |=> txrdy_n); // R9

endmodule

bind uart_fifo_ctl ufc_checker #(.W(W), .DEPTH(DEPTH)) i_ufc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en      (fifo_en),
  .dma_mode     (dma_mode),
  .rx_sel       (rx_sel),
  .tx_sel       (tx_sel),
  .rx_count     (rx_count),
  .tx_count     (tx_count),
  .rx_flush     (rx_flush),
  .tx_flush     (tx_flush),
  .tx_push      (tx_push),
  .rx_overrun   (rx_overrun),
  .rx_irq       (rx_irq),
  .rxrdy_n      (rxrdy_n),
  .txrdy_n      (txrdy_n),
  .tx_ser_pop   (tx_ser_pop),
  .tx_ser_empty (tx_ser_empty),
  .tx_ser_data  (tx_ser_data)
);

// File: tb/test_uart_fifo_ctl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       tx_in_valid = 1'b0;
  logic       tx_in_ready;
  logic [7:0] tx_in_data = '0;
  logic       rx_out_valid;
  logic       rx_out_ready = 1'b0;
  logic [7:0] rx_out_data;
  logic       rx_ser_push = 1'b0;
  logic [7:0] rx_ser_data = '0;
  logic       rx_overrun;
  logic       tx_ser_pop = 1'b0;
  logic [7:0] tx_ser_data;
  logic       tx_ser_empty;
  logic       rx_irq, tx_irq, rxrdy_n, txrdy_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_fifo_ctl i_uart_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .rx_ser_push(rx_ser_push), .rx_ser_data(rx_ser_data), .rx_overrun(rx_overrun),
    .tx_ser_pop(tx_ser_pop), .tx_ser_data(tx_ser_data), .tx_ser_empty(tx_ser_empty),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
  );

  // {control, rx pushes, tx writes, expected {rx_irq, tx_irq, rxrdy_n, txrdy_n}}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 6'd0,  6'd0,  4'b0110},
    {8'h00, 6'd1,  6'd1,  4'b1001},
    {8'h01, 6'd7,  6'd15, 4'b0101},
    {8'h01, 6'd8,  6'd16, 4'b1001},
    {8'h09, 6'd7,  6'd15, 4'b0110},
    {8'h09, 6'd8,  6'd16, 4'b1001},
    {8'h49, 6'd15, 6'd0,  4'b0110},
    {8'h59, 6'd16, 6'd8,  4'b1001},
    {8'h89, 6'd24, 6'd7,  4'b1100},
    {8'hE9, 6'd27, 6'd24, 4'b0011},
    {8'hF9, 6'd32, 6'd29, 4'b1100},
    {8'hF1, 6'd0,  6'd30, 4'b0011},
    {8'h08, 6'd1,  6'd1,  4'b1001}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic push_rx(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_ser_push = 1'b1; rx_ser_data = 8'(base + i);
    end
    @(negedge clk); rx_ser_push = 1'b0;
  endtask

  task automatic write_tx(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_in_valid = 1'b1; tx_in_data = 8'(base + i);
    end
    @(negedge clk); tx_in_valid = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_ser_pop = 1'b1;
    @(negedge clk); tx_ser_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=hang expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "rx_irq", rx_irq, 0);
    chk("R1", "tx_irq", tx_irq, 0);
    chk("R1", "rxrdy_n", rxrdy_n, 1);
    chk("R1", "txrdy_n", txrdy_n, 1);
    chk("R1", "rx_out_valid", rx_out_valid, 0);
    chk("R1", "rx_overrun", rx_overrun, 0);
    chk("R1", "tx_ser_empty", tx_ser_empty, 1);
    rst_n = 1'b1;

    // table of thresholds and request modes: R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [7:0] f;
      logic [3:0] e;
      string rq;
      f = VEC[v][23:16];
      e = VEC[v][3:0];
      rq = (f[0] && f[3]) ? "R9" : "R8";
      wr_ctl(f | 8'h06);
      push_rx(int'(VEC[v][15:10]), 0);
      write_tx(int'(VEC[v][9:4]), 0);
      @(negedge clk);
      chk("R6", $sformatf("rx_irq row %0d", v), rx_irq, e[3]);
      chk("R7", $sformatf("tx_irq row %0d", v), tx_irq, e[2]);
      chk(rq, $sformatf("rxrdy_n row %0d", v), rxrdy_n, e[1]);
      chk(rq, $sformatf("txrdy_n row %0d", v), txrdy_n, e[0]);
    end

    // R10: one-cycle registered latency
    wr_ctl(8'h07);
    @(negedge clk);
    rx_ser_push = 1'b1; rx_ser_data = 8'h11;
    @(negedge clk); rx_ser_push = 1'b0;
    chk("R2", "rx_out_valid after push", rx_out_valid, 1);
    chk("R10", "rxrdy_n same cycle as count", rxrdy_n, 1);
    @(negedge clk);
    chk("R10", "rxrdy_n one cycle later", rxrdy_n, 0);

    // R2: ordering through the host read stream
    push_rx(2, 8'h22 - 0);
    @(negedge clk); rx_out_ready = 1'b1;
    chk("R2", "read 0", rx_out_data, 8'h11);
    @(negedge clk); chk("R2", "read 1", rx_out_data, 8'h22);
    @(negedge clk); chk("R2", "read 2", rx_out_data, 8'h23);
    @(negedge clk); rx_out_ready = 1'b0;
    chk("R2", "valid after drain", rx_out_valid, 0);

    // R3: overrun on the 33rd push, stored data intact
    wr_ctl(8'h07);
    push_rx(33, 0);
    chk("R3", "overrun set", rx_overrun, 1);
    rx_out_ready = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (rx_out_data !== 8'(i)) chk("R3", $sformatf("data %0d", i), rx_out_data, i);
      @(negedge clk);
    end
    rx_out_ready = 1'b0;
    chk("R3", "32 entries stored", rx_out_valid, 0);
    chk("R3", "overrun sticky", rx_overrun, 1);
    wr_ctl(8'h03);
    chk("R5", "rx flush clears overrun", rx_overrun, 0);

    // R4: pop from empty transmit queue
    wr_ctl(8'h07);
    write_tx(1, 8'hA5);
    chk("R4", "head data", tx_ser_data, 8'hA5);
    pop_tx();
    chk("R4", "empty after pop", tx_ser_empty, 1);
    chk("R4", "last value shown", tx_ser_data, 8'hA5);
    pop_tx();
    chk("R4", "empty pop keeps data", tx_ser_data, 8'hA5);
    write_tx(1, 8'h5A);
    chk("R4", "count not wrapped", tx_ser_empty, 0);
    chk("R4", "new head", tx_ser_data, 8'h5A);

    // R5: tx flush leaves rx alone; enable change empties both
    push_rx(1, 8'h77);
    wr_ctl(8'h05);
    chk("R5", "tx flushed", tx_ser_empty, 1);
    chk("R5", "rx untouched", rx_out_valid, 1);
    wr_ctl(8'h00);
    chk("R5", "enable change flushes rx", rx_out_valid, 0);

    // R2/R3: disabled mode holds one character
    write_tx(1, 8'h10);
    chk("R2", "tx holder full", tx_in_ready, 0);
    push_rx(2, 8'h40);
    chk("R3", "second char overruns", rx_overrun, 1);
    chk("R2", "first char kept", rx_out_data, 8'h40);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule